// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (either 24-hour or 12-hour with a PM flag), day of week, day of month, month and a two-digit year. It is clocked by the system clock. A one-cycle `tick_en` strobe at the 32.768 kHz rate feeds an internal prescaler that turns a parameterised number of ticks into a one-second step. Every field that changes on a step changes on the same clock edge.

Software uses a byte-wide register port. It writes a control byte to run or halt the counter, select the hour format or request a self-clearing soft reset. To load the time, software clears the run bit and polls the acknowledged run bit until it reads 0. It then writes the time fields and sets the run bit again. A carry flag records every one-second step. Software clears the carry flag, reads all fields, and reads the flag again: a set flag means the read straddled an update. Reads are combinational from the address. Writes are single-cycle strobes and need no handshake.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After hardware reset the fields read as second 00, minute 00, hour 00, weekday 0, day 01, month 01 and year 00. Address 0 reads 0x04 and address 1 reads 0x00.
- R2: Address 0 holds the control byte: bit 0 requests running, bit 1 requests soft reset, bit 2 selects the 24-hour format. Reading bit 0 gives the acknowledged run state. This state takes the requested value only on the next `tick_en` pulse.
- R3: While acknowledged running, the time advances by one second on every TICKS_PER_SEC-th `tick_en` pulse. The tick on which running is acknowledged is not counted. While the counter is stopped, the time does not advance and the prescaler restarts from zero.
- R4: Seconds and minutes count 00 to 59 in BCD and carry into the next field. In 24-hour mode, hour 23 rolls to 00 and advances the date.
- R5: In 12-hour mode the hour holds BCD 01 to 12, and bit 6 is the PM flag. The hour steps from 11 AM to 12 PM, from 12 PM to 01 PM, and from 11 PM to 12 AM. The step from 11 PM to 12 AM advances the date.
- R6: The day of month rolls over after 30 in April, June, September and November, and after 31 in the other long months. February ends on 29 when the BCD year is divisible by 4 and on 28 otherwise.
- R7: On each date advance the weekday steps 0 to 6 and wraps to 0. Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R8: Addresses 2 to 8 are second, minute, hour, weekday, day, month and year. A write to one of them takes effect only while the acknowledged run state is 0, and is masked to 7, 7, 7, 3, 6, 5 and 8 low bits respectively. A write made while running has no effect.
- R9: Address 1 bit 0 is the carry flag, set on every one-second step. Writing bit 0 as 0 clears it, and writing it as 1 leaves the flag unchanged.
- R10: Writing control bit 1 as 1 makes it read 1 until the next `tick_en`. On that pulse every field takes its reset value, the prescaler clears, and the bit reads 0 again. The hour reset value is 00 in 24-hour mode and 12 AM (0x12) in 12-hour mode.
- R11: With no one-second step, no accepted write and no soft reset in a cycle, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at the 32.768 kHz tick rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The assertions check three things on every cycle:
- the prescaler stays in range;
- the acknowledged run state changes only on a tick;
- fields stay put while running without a step, and also hold in idle cycles.

They also check that the carry flag follows each step, that a soft reset clears itself on its tick, and that a step keeps the seconds and weekday legal. Only the bench scenarios can show the calendar arithmetic itself. That covers the 12-hour sequence, month lengths and leap years, and year wrap. It also covers the masking of loaded values and the exact tick on which a start, a stop or a soft reset lands.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  // field index i lives in bits [8*i +: 8]; index order equals register order
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mdy;
    logic [7:0] wdy;
    logic [7:0] hr;
    logic [7:0] mnt;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'b0, y[7:4]} * 8'd10) + {4'b0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_init(input int idx, input logic mode24);
    case (idx)
      2:       return mode24 ? 8'h00 : 8'h12;
      4, 5:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clear,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = run && tick_en && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear || !run)  cnt_q <= '0;
    else if (tick_en)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && run && !clear) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       sec_pulse,
  input  logic       ctrl_we,
  input  logic       stat_we,
  input  logic [7:0] wdata,
  output logic       run_ack,
  output logic       mode24,
  output logic       rst_busy,
  output logic       init_now,
  output logic       carry
);
  logic run_req;

  assign init_now = rst_busy && tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req  <= 1'b0;
      run_ack  <= 1'b0;
      mode24   <= 1'b1;
      rst_busy <= 1'b0;
      carry    <= 1'b0;
    end else begin
      if (ctrl_we) begin
        run_req <= wdata[0];
        mode24  <= wdata[2];
      end
      if (ctrl_we && wdata[1]) rst_busy <= 1'b1;
      else if (init_now)       rst_busy <= 1'b0;
      if (tick_en) run_ack <= run_req;
      if (sec_pulse)                carry <= 1'b1;
      else if (stat_we && !wdata[0]) carry <= 1'b0;
    end
  end

  AST_ACK_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(run_ack)); // R2
  AST_CARRY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> carry); // R9
  AST_RESET_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && tick_en && !ctrl_we) |=> !rst_busy); // R10

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_pulse,
  input  logic                    init,
  input  logic                    mode24,
  input  logic                    fld_we,
  input  logic [SEL_W-1:0]        fld_sel,
  input  logic [7:0]              fld_wdata,
  output logic [8*NUM_FIELDS-1:0] cal_flat
);
  logic [7:0] fld_q [NUM_FIELDS];
  cal_t cur, nxt;
  logic [7:0] hinc;
  logic min_c, hr_c, day_c, mon_c, yr_c;
  logic sec_ok, wdy_ok;

  assign cur    = cal_t'(cal_flat);
  assign hinc   = bcd_inc({2'b00, cur.hr[5:0]});
  assign sec_ok = (cur.sec[3:0] <= 4'd9) && (cur.sec <= 8'h59);
  assign wdy_ok = (cur.wdy <= 8'd6);

  always_comb begin
    nxt   = cur;
    min_c = 1'b0; hr_c = 1'b0; day_c = 1'b0; mon_c = 1'b0; yr_c = 1'b0;
    if (cur.sec >= 8'h59) begin nxt.sec = 8'h00; min_c = 1'b1; end
    else nxt.sec = bcd_inc(cur.sec);
    if (min_c) begin
      if (cur.mnt >= 8'h59) begin nxt.mnt = 8'h00; hr_c = 1'b1; end
      else nxt.mnt = bcd_inc(cur.mnt);
    end
    if (hr_c) begin
      if (mode24) begin
        if (cur.hr[5:0] >= 6'h23) begin nxt.hr = 8'h00; day_c = 1'b1; end
        else nxt.hr = {2'b00, hinc[5:0]};
      end else if (cur.hr[5:0] == 6'h11) begin
        nxt.hr = {1'b0, ~cur.hr[6], 6'h12};
        day_c  = cur.hr[6];
      end else if (cur.hr[5:0] >= 6'h12) begin
        nxt.hr = {1'b0, cur.hr[6], 6'h01};
      end else begin
        nxt.hr = {1'b0, cur.hr[6], hinc[5:0]};
      end
    end
    if (day_c) begin
      nxt.wdy = (cur.wdy >= 8'd6) ? 8'd0 : cur.wdy + 8'd1;
      if (cur.mdy >= month_last_day(cur.mon, cur.yr)) begin nxt.mdy = 8'h01; mon_c = 1'b1; end
      else nxt.mdy = bcd_inc(cur.mdy);
    end
    if (mon_c) begin
      if (cur.mon >= 8'h12) begin nxt.mon = 8'h01; yr_c = 1'b1; end
      else nxt.mon = bcd_inc(cur.mon);
    end
    if (yr_c) nxt.yr = (cur.yr >= 8'h99) ? 8'h00 : bcd_inc(cur.yr);
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
    logic [8*NUM_FIELDS-1:0] nxt_flat;
    assign nxt_flat = nxt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fld_q[gi] <= field_init(gi, 1'b1);
      else if (init)      fld_q[gi] <= field_init(gi, mode24);
      else if (sec_pulse) fld_q[gi] <= nxt_flat[8*gi +: 8];
      else if (fld_we && (fld_sel == SEL_W'(gi)))
                          fld_q[gi] <= fld_wdata & field_mask(gi);
    end
    assign cal_flat[8*gi +: 8] = fld_q[gi];
  end

  AST_IDLE_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !fld_we && !init) |=> $stable(cal_flat)); // R11
  AST_SEC_STAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !init && sec_ok) |=> sec_ok); // R4
  AST_WDAY_STAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !init && wdy_ok) |=> wdy_ok); // R7

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int FLD_BASE = 2;
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLD_LO  = ADDR_W'(FLD_BASE);
  localparam logic [ADDR_W-1:0] A_FLD_END = ADDR_W'(FLD_BASE + NUM_FIELDS);

  logic run_ack, mode24, rst_busy, init_now, carry, sec_pulse;
  logic is_fld, fld_we;
  logic [ADDR_W-1:0] fld_off;
  logic [SEL_W-1:0]  fld_sel;
  logic [7:0]        fld_rd;
  logic [8*NUM_FIELDS-1:0] cal_flat;

  assign is_fld  = (reg_addr >= A_FLD_LO) && (reg_addr < A_FLD_END);
  assign fld_off = reg_addr - A_FLD_LO;
  assign fld_sel = fld_off[SEL_W-1:0];
  assign fld_we  = reg_wr && is_fld && !run_ack;

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sec_pulse(sec_pulse),
    .ctrl_we(reg_wr && (reg_addr == A_CTRL)), .stat_we(reg_wr && (reg_addr == A_STAT)),
    .wdata(reg_wdata), .run_ack(run_ack), .mode24(mode24), .rst_busy(rst_busy),
    .init_now(init_now), .carry(carry)
  );

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run_ack),
    .clear(init_now), .sec_pulse(sec_pulse)
  );

  rtc_calendar_core u_core (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .init(init_now),
    .mode24(mode24), .fld_we(fld_we), .fld_sel(fld_sel), .fld_wdata(reg_wdata),
    .cal_flat(cal_flat)
  );

  always_comb begin
    fld_rd = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (fld_sel == SEL_W'(i)) fld_rd = cal_flat[8*i +: 8];
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_CTRL)      reg_rdata = {5'b0, mode24, rst_busy, run_ack};
    else if (reg_addr == A_STAT) reg_rdata = {7'b0, carry};
    else if (is_fld)             reg_rdata = fld_rd;
  end

  AST_RUNNING_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ack && !sec_pulse && !init_now) |=> $stable(cal_flat)); // R8
  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (run_ack && tick_en)); // R3

endmodule

// File: tb/sim_bcd_calendar_rtc.sv
module sim_bcd_calendar_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state, binary
  int ms, mm, mh, mwd, mmd, mmo, myr;
  bit m24 = 1'b1, mreq = 1'b0, mack = 1'b0, mbusy = 1'b0, mcarry = 1'b0;
  int pcnt = 0;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hour_code(input int h, input bit f24);
    if (f24) return bcd(h);
    if (h == 0) return 8'h12;
    if (h < 12) return bcd(h);
    if (h == 12) return 8'h52;
    return bcd(h - 12) | 8'h40;
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_init();
    ms = 0; mm = 0; mh = 0; mwd = 0; mmd = 1; mmo = 1; myr = 0;
  endtask

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0; mwd = (mwd + 1) % 7; mmd++;
      if (mmd > days_in(mmo, myr)) begin mmd = 1; mmo++; end
      if (mmo == 13) begin mmo = 1; myr = (myr + 1) % 100; end
    end
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    reg_addr = 4'(a);
    #1 v = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    if (mbusy) begin
      model_init(); pcnt = 0; mbusy = 1'b0;
    end else if (mack) begin
      pcnt++;
      if (pcnt == TPS) begin pcnt = 0; model_step(); mcarry = 1'b1; end
    end
    mack = mreq;
    if (!mack) pcnt = 0;
  endtask

  task automatic ctrl_wr(input bit run, input bit srst);
    wr(0, {5'b0, m24, srst, run});
    mreq = run;
    if (srst) mbusy = 1'b1;
  endtask

  task automatic check_ctrl(input string req);
    logic [7:0] v;
    rd(0, v); chk(v, {5'b0, m24, mbusy, mack}, req);
  endtask

  task automatic check_time(input string req);
    logic [7:0] v;
    rd(2, v); chk(v, bcd(ms), req);
    rd(3, v); chk(v, bcd(mm), req);
    rd(4, v); chk(v, hour_code(mh, m24), req);
    rd(5, v); chk(v, bcd(mwd), req);
    rd(6, v); chk(v, bcd(mmd), req);
    rd(7, v); chk(v, bcd(mmo), req);
    rd(8, v); chk(v, bcd(myr), req);
  endtask

  task automatic load(input bit f24, input int s, input int m, input int h,
                      input int wd, input int md, input int mo, input int yr);
    m24 = f24;
    ctrl_wr(1'b0, 1'b0);
    if (mack) tick();
    wr(2, bcd(s)); wr(3, bcd(m)); wr(4, hour_code(h, f24)); wr(5, bcd(wd));
    wr(6, bcd(md)); wr(7, bcd(mo)); wr(8, bcd(yr));
    ms = s; mm = m; mh = h; mwd = wd; mmd = md; mmo = mo; myr = yr;
  endtask

  task automatic run_case(input int nticks, input string req);
    ctrl_wr(1'b1, 1'b0);
    tick();
    repeat (nticks) tick();
    check_time(req);
    ctrl_wr(1'b0, 1'b0);
    tick();
    check_time(req);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog got timeout exp completion");
    report();
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(0, v); chk(v, 8'h04, "R1");
    rd(1, v); chk(v, 8'h00, "R1");
    check_time("R1");

    // R2 handshake: ack only after a tick
    ctrl_wr(1'b1, 1'b0);
    check_ctrl("R2");
    tick();
    check_ctrl("R2");
    repeat (3 * TPS) tick();
    check_time("R3");
    rd(1, v); chk(v, {7'b0, mcarry}, "R9");
    wr(1, 8'h01); rd(1, v); chk(v, 8'h01, "R9");
    wr(1, 8'hFE); mcarry = 1'b0; rd(1, v); chk(v, 8'h00, "R9");

    // R8 write while running is ignored
    wr(2, 8'h45);
    check_time("R8");

    // stop, then ticks must not advance
    ctrl_wr(1'b0, 1'b0);
    check_ctrl("R2");
    tick();
    check_ctrl("R2");
    repeat (2 * TPS) tick();
    check_time("R3");

    // directed calendar corners
    load(1'b1, 59, 59, 23, 6, 31, 12, 99); run_case(TPS, "R7");
    load(1'b1, 59, 59, 23, 2, 28, 2, 24);  run_case(TPS, "R6");
    load(1'b1, 59, 59, 23, 2, 28, 2, 23);  run_case(TPS, "R6");
    load(1'b1, 59, 59, 23, 3, 29, 2, 24);  run_case(TPS, "R6");
    load(1'b1, 59, 59, 23, 1, 30, 4, 10);  run_case(TPS, "R6");
    load(1'b1, 58, 59, 22, 1, 15, 7, 10);  run_case(3 * TPS, "R4");
    load(1'b0, 59, 59, 11, 0, 10, 5, 30);  run_case(TPS, "R5");
    load(1'b0, 59, 59, 12, 0, 10, 5, 30);  run_case(TPS, "R5");
    load(1'b0, 59, 59, 23, 6, 31, 5, 30);  run_case(TPS, "R5");

    // R8 masking while stopped
    wr(2, 8'hFF); rd(2, v); chk(v, 8'h7F, "R8");
    wr(5, 8'hFF); rd(5, v); chk(v, 8'h07, "R8");
    wr(7, 8'hFF); rd(7, v); chk(v, 8'h1F, "R8");

    // R10 soft reset in 12-hour mode
    m24 = 1'b0;
    ctrl_wr(1'b0, 1'b1);
    check_ctrl("R10");
    tick();
    check_ctrl("R10");
    check_time("R10");

    // constrained random
    for (int it = 0; it < 40; it++) begin
      int mo, yr, md, h, m, s, wd;
      bit f24;
      f24 = 1'($urandom % 2);
      mo = 1 + int'($urandom % 12);
      yr = int'($urandom % 100);
      md = ($urandom % 3 == 0) ? days_in(mo, yr) : 1 + int'($urandom % days_in(mo, yr));
      h  = ($urandom % 3 == 0) ? ((it % 3 == 0) ? 11 : (it % 3 == 1) ? 12 : 23)
                               : int'($urandom % 24);
      m  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s  = ($urandom % 2 == 0) ? 59 - int'($urandom % 2) : int'($urandom % 60);
      wd = int'($urandom % 7);
      load(f24, s, m, h, wd, md, mo, yr);
      run_case(int'($urandom % (3 * TPS + 3)), "R4");
      rd(1, v); chk(v, {7'b0, mcarry}, "R9");
      wr(1, 8'hFE); mcarry = 1'b0;
    end

    report();
  end

endmodule